// File: doc/BRIEF.md
# Interrupt Acceptance Gate with Nonmaskable Blocking

This block decides, for one processor core, whether an interrupt is taken at the current retirement point and which vector is dispatched. Two request paths feed it. The first is a nonmaskable path. It can be fed by a rising edge on a dedicated pin or by a bus message whose delivery-mode field selects the nonmaskable kind. The second is a level-sensitive maskable request that carries its own 8-bit vector and is gated by the interrupt-enable flag.

Acceptance happens only when the core signals an in-order boundary. That boundary is either the retirement of a whole instruction or the end of one iteration of a repeated instruction. In the cycle after the decision the block issues a one-cycle take pulse. The pulse comes with the vector and the address at which the interrupted program resumes. When the maskable path was served, an acknowledge is raised alongside it.

A nonmaskable acceptance raises a blocking state. While that state is set, nothing further is taken, including another nonmaskable request. The state clears only on a handler-return pulse.

Top module: `intr_gate`

## Requirements
- R1: A nonmaskable request is raised by a rising edge of `nmi_pin` or by a cycle with `msg_valid`=1 and `msg_mode`=3'b100. Any other mode value raises nothing. The request dispatches vector 2. A pin held high yields exactly one request.
- R2: `if_flag`=0 suppresses only the maskable path. A nonmaskable request is taken whatever `if_flag` holds.
- R3: After a nonmaskable acceptance, `nmi_blocked` reads 1 from the take cycle onward, and no interrupt of any kind is taken. A `handler_ret` pulse while blocked clears the state at the next edge. A boundary in the same cycle as that pulse is still refused.
- R4: A take is decided only in a cycle with `retire_bnd` or `rep_bnd` high. Without a boundary strobe no take occurs, even with requests waiting.
- R5: The saved return address is `next_addr` for a retirement boundary. It is `instr_addr` (the repeated instruction) when `rep_bnd` is high, and `rep_bnd` wins when both strobes are high.
- R6: A maskable request carrying vector 2 dispatches vector 2 with `intr_ack`=1, remains subject to `if_flag`, and leaves `nmi_blocked` at 0.
- R7: One nonmaskable request arriving while blocked or while one is already waiting is held and taken at the first boundary after blocking clears. Further arrivals while one is waiting are dropped.
- R8: When a waiting nonmaskable request and an enabled maskable request meet at one boundary, the nonmaskable one is taken (vector 2, `intr_ack`=0). The maskable request is served at a later boundary if still asserted.
- R9: A `handler_ret` pulse while not blocked has no effect on `nmi_blocked` or on later acceptance.
- R10: `take`, `vec`, `ret_addr` and `intr_ack` are registered and appear in the cycle after the deciding boundary. `intr_ack` is 1 only with a maskable take, and `take` is a single-cycle pulse per accepted request.
- R11: During and after reset, `take`, `intr_ack`, `nmi_blocked`, `vec` and `ret_addr` are 0 and no request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | External nonmaskable pin, rising-edge detected |
| msg_valid | input | 1 | Bus message strobe |
| msg_mode | input | 3 | Delivery-mode field of the bus message |
| intr_req | input | 1 | Level-sensitive maskable request |
| intr_vec | input | 8 | Vector of the maskable request |
| if_flag | input | 1 | Interrupt-enable flag |
| retire_bnd | input | 1 | Instruction retirement boundary strobe |
| rep_bnd | input | 1 | End-of-iteration strobe of a repeated instruction |
| next_addr | input | 32 | Address of the next instruction to execute |
| instr_addr | input | 32 | Address of the instruction being repeated |
| handler_ret | input | 1 | Return-from-handler pulse |
| take | output | 1 | One-cycle interrupt acceptance pulse |
| vec | output | 8 | Dispatched vector |
| ret_addr | output | 32 | Saved return address |
| intr_ack | output | 1 | Acknowledge of the maskable request |
| nmi_blocked | output | 1 | Nonmaskable blocking state |

## Verification
The hardest situation to reach is a second nonmaskable request that waits out a blocking period and is then taken. The bench holds an accepted request's handler open and fires several bus messages and a pin edge into the blocked window. It then checks that one request survives the return pulse, that the boundary coinciding with the return is refused, and that the surplus arrivals were dropped. The maskable path is swept over every vector with both flag values, and the bus path is swept over every delivery-mode code.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_INTR = 2'd2
  } src_e;
endpackage

// File: rtl/intr_gate_nmi_track.sv
module intr_gate_nmi_track #(
  parameter int MODE_W   = 3,
  parameter int MODE_NMI = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_pin,
  input  logic              msg_valid,
  input  logic [MODE_W-1:0] msg_mode,
  input  logic              take_nmi,
  input  logic              handler_ret,
  output logic              pending,
  output logic              blocked
);
  logic pin_q;
  logic nmi_event;

  assign nmi_event = (nmi_pin & ~pin_q) |
                     (msg_valid & (msg_mode == MODE_W'(MODE_NMI)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q   <= 1'b0;
      pending <= 1'b0;
      blocked <= 1'b0;
    end else begin
      pin_q <= nmi_pin;
      if (take_nmi) pending <= nmi_event;
      else          pending <= pending | nmi_event;
      if (take_nmi)                   blocked <= 1'b1;
      else if (handler_ret & blocked) blocked <= 1'b0;
    end
  end

  // R9: without a fresh acceptance, blocking cannot appear (return pulse irrelevant)
  assert_ret_no_effect_R9: assert property (@(posedge clk) disable iff (rst)
    (!blocked && !take_nmi) |=> !blocked);
  // R7: a waiting request is held until it is consumed
  assert_pending_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pending && !take_nmi) |=> pending);
  // R3: blocking persists until a return pulse
  assert_block_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (blocked && !handler_ret) |=> blocked);
endmodule

// File: rtl/intr_gate_arb.sv
module intr_gate_arb
  import intr_gate_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int NMI_VEC = 2
) (
  input  logic              pending,
  input  logic              blocked,
  input  logic              intr_req,
  input  logic              if_flag,
  input  logic [VEC_W-1:0]  intr_vec,
  input  logic              retire_bnd,
  input  logic              rep_bnd,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [ADDR_W-1:0] instr_addr,
  output src_e              src,
  output logic [VEC_W-1:0]  sel_vec,
  output logic [ADDR_W-1:0] sel_ret
);
  logic boundary;
  assign boundary = retire_bnd | rep_bnd;

  always_comb begin
    src     = SRC_NONE;
    sel_vec = intr_vec;
    if (boundary && !blocked) begin
      if (pending) begin
        src     = SRC_NMI;
        sel_vec = VEC_W'(NMI_VEC);
      end else if (intr_req && if_flag) begin
        src = SRC_INTR;
      end
    end
    sel_ret = rep_bnd ? instr_addr : next_addr;
  end
endmodule

// File: rtl/intr_gate.sv
module intr_gate
  import intr_gate_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 32,
  parameter int MODE_W   = 3,
  parameter int MODE_NMI = 4,
  parameter int NMI_VEC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_pin,
  input  logic              msg_valid,
  input  logic [MODE_W-1:0] msg_mode,
  input  logic              intr_req,
  input  logic [VEC_W-1:0]  intr_vec,
  input  logic              if_flag,
  input  logic              retire_bnd,
  input  logic              rep_bnd,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic              handler_ret,
  output logic              take,
  output logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              intr_ack,
  output logic              nmi_blocked
);
  src_e              src;
  logic              pending;
  logic              blocked;
  logic [VEC_W-1:0]  sel_vec;
  logic [ADDR_W-1:0] sel_ret;
  logic              take_nmi;

  assign take_nmi    = (src == SRC_NMI);
  assign nmi_blocked = blocked;

  intr_gate_nmi_track #(.MODE_W(MODE_W), .MODE_NMI(MODE_NMI)) u_track (
    .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .msg_valid(msg_valid),
    .msg_mode(msg_mode), .take_nmi(take_nmi), .handler_ret(handler_ret),
    .pending(pending), .blocked(blocked)
  );

  intr_gate_arb #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC)) u_arb (
    .pending(pending), .blocked(blocked), .intr_req(intr_req),
    .if_flag(if_flag), .intr_vec(intr_vec), .retire_bnd(retire_bnd),
    .rep_bnd(rep_bnd), .next_addr(next_addr), .instr_addr(instr_addr),
    .src(src), .sel_vec(sel_vec), .sel_ret(sel_ret)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      intr_ack <= 1'b0;
      vec      <= '0;
      ret_addr <= '0;
    end else begin
      take     <= (src != SRC_NONE);
      intr_ack <= (src == SRC_INTR);
      if (src != SRC_NONE) begin
        vec      <= sel_vec;
        ret_addr <= sel_ret;
      end
    end
  end

  // R3: nothing is taken while blocked
  assert_no_take_blocked_R3: assert property (@(posedge clk) disable iff (rst)
    nmi_blocked |=> !take);
  // R4: a take needs a boundary in the deciding cycle
  assert_boundary_only_R4: assert property (@(posedge clk) disable iff (rst)
    !(retire_bnd || rep_bnd) |=> !take);
  // R6: a maskable take never leaves blocking set
  assert_intr_no_block_R6: assert property (@(posedge clk) disable iff (rst)
    (take && intr_ack) |-> !nmi_blocked);
  // R1: a nonmaskable take dispatches its fixed vector and blocks
  assert_nmi_vec_R1: assert property (@(posedge clk) disable iff (rst)
    (take && !intr_ack) |-> (nmi_blocked && vec == VEC_W'(NMI_VEC)));
  // R2: a maskable take only happens with the enable flag set
  assert_if_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (!if_flag || !intr_req) |=> !intr_ack);
  // R10: acknowledge only accompanies a take
  assert_ack_with_take_R10: assert property (@(posedge clk) disable iff (rst)
    intr_ack |-> take);
endmodule

// File: tb/intr_gate_tb.sv
module intr_gate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_pin = 0, msg_valid = 0, intr_req = 0, if_flag = 0;
  logic [2:0]  msg_mode = 0;
  logic [7:0]  intr_vec = 0;
  logic        retire_bnd = 0, rep_bnd = 0, handler_ret = 0;
  logic [31:0] next_addr = 0, instr_addr = 0;
  logic        take, intr_ack, nmi_blocked;
  logic [7:0]  vec;
  logic [31:0] ret_addr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  intr_gate u_dut (
    .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .msg_valid(msg_valid),
    .msg_mode(msg_mode), .intr_req(intr_req), .intr_vec(intr_vec),
    .if_flag(if_flag), .retire_bnd(retire_bnd), .rep_bnd(rep_bnd),
    .next_addr(next_addr), .instr_addr(instr_addr), .handler_ret(handler_ret),
    .take(take), .vec(vec), .ret_addr(ret_addr), .intr_ack(intr_ack),
    .nmi_blocked(nmi_blocked)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    msg_valid = 0; retire_bnd = 0; rep_bnd = 0; handler_ret = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R11 take", take, 0); chk("R11 ack", intr_ack, 0);
    chk("R11 blk", nmi_blocked, 0); chk("R11 vec", vec, 0);
    chk("R11 ret", ret_addr, 0);
    rst = 0;
    tick();
    chk("R11 no pending", take, 0);

    // R2 R6 R4 R10: maskable sweep over every vector, both flag values
    for (int f = 0; f < 2; f++) begin
      for (int v = 0; v < 256; v++) begin
        intr_req = 1; if_flag = f[0]; intr_vec = v[7:0];
        tick();
        chk("R4 no boundary", take, 0);
        retire_bnd = 1; next_addr = 32'h1000 + v * 4;
        tick();
        intr_req = 0;
        chk("R2 take", take, f);
        chk("R10 ack", intr_ack, f);
        if (f == 1) begin
          chk("R6 vec", vec, v);
          chk("R5 ret", ret_addr, 32'h1000 + v * 4);
        end
        chk("R6 blk", nmi_blocked, 0);
        tick();
        chk("R10 pulse", take, 0);
      end
    end

    // R1 R2: delivery-mode sweep with flag cleared
    if_flag = 0;
    for (int m = 0; m < 8; m++) begin
      msg_valid = 1; msg_mode = m[2:0];
      tick();
      retire_bnd = 1; next_addr = 32'h2000 + m;
      tick();
      chk("R1 take", take, (m == 4));
      chk("R2 ack", intr_ack, 0);
      chk("R1 blk", nmi_blocked, (m == 4));
      if (m == 4) begin
        chk("R1 vec", vec, 2);
        chk("R5 ret", ret_addr, 32'h2004);
        handler_ret = 1;
        tick();
        tick();
        chk("R3 cleared", nmi_blocked, 0);
      end
    end

    // R1: pin edge, held level gives one request
    nmi_pin = 1;
    tick();
    retire_bnd = 1; next_addr = 32'h3000;
    tick();
    chk("R1 pin take", take, 1); chk("R1 pin vec", vec, 2);
    handler_ret = 1;
    tick();
    retire_bnd = 1;
    tick();
    chk("R1 held level", take, 0);
    nmi_pin = 0;
    tick();

    // R5: repeat boundary returns to the repeated instruction
    msg_valid = 1; msg_mode = 3'b100;
    tick();
    rep_bnd = 1; retire_bnd = 1; instr_addr = 32'hA0; next_addr = 32'hB0;
    tick();
    chk("R5 rep wins", ret_addr, 32'hA0);
    handler_ret = 1;
    tick();
    intr_req = 1; if_flag = 1; intr_vec = 8'h33;
    rep_bnd = 1; instr_addr = 32'hC0; next_addr = 32'hD0;
    tick();
    intr_req = 0;
    chk("R5 rep intr", ret_addr, 32'hC0); chk("R5 rep ack", intr_ack, 1);

    // R8 R3 R7: priority, blocking, waiting request
    msg_valid = 1; msg_mode = 3'b100;
    tick();
    intr_req = 1; if_flag = 1; intr_vec = 8'h40; retire_bnd = 1; next_addr = 32'h10;
    tick();
    chk("R8 nmi wins", take, 1); chk("R8 vec", vec, 2); chk("R8 ack", intr_ack, 0);
    chk("R3 blk", nmi_blocked, 1);
    retire_bnd = 1;
    tick();
    chk("R3 intr refused", take, 0);
    msg_valid = 1;
    tick();
    msg_valid = 1;
    tick();
    nmi_pin = 1;
    tick();
    nmi_pin = 0;
    handler_ret = 1; retire_bnd = 1;
    tick();
    chk("R3 same-cycle boundary", take, 0);
    chk("R3 unblocked", nmi_blocked, 0);
    retire_bnd = 1;
    tick();
    chk("R7 held taken", take, 1); chk("R7 vec", vec, 2); chk("R7 blk", nmi_blocked, 1);
    handler_ret = 1;
    tick();
    retire_bnd = 1;
    tick();
    chk("R8 intr later", take, 1); chk("R8 intr vec", vec, 8'h40);
    chk("R7 surplus dropped ack", intr_ack, 1);
    intr_req = 0;
    retire_bnd = 1;
    tick();
    chk("R7 surplus dropped", take, 0);

    // R9: return pulse while unblocked
    handler_ret = 1;
    tick();
    chk("R9 blk", nmi_blocked, 0);
    intr_req = 1; intr_vec = 8'h02; if_flag = 1; retire_bnd = 1;
    tick();
    intr_req = 0;
    chk("R9 R6 vec2 take", vec, 2); chk("R6 vec2 ack", intr_ack, 1);
    chk("R6 vec2 blk", nmi_blocked, 0);
    handler_ret = 1;
    tick();
    msg_valid = 1; msg_mode = 3'b100;
    tick();
    retire_bnd = 1;
    tick();
    chk("R9 nmi still works", take, 1); chk("R9 blk set", nmi_blocked, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule